// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the sixteen 32-bit general registers of a processor core. Each of them can have more than one physical copy, one per operating mode. A 5-bit mode value selects the bank in force. Registers 0 to 7 and register 15 have a single physical copy that every mode shares. Registers 13 and 14 have their own copy in each bank. The fast-interrupt bank also keeps private copies of registers 8 to 12, which all the other banks share. Mode values that map to no bank select a scratch bank whose upper registers read as zero.

The core reads and writes through two combinational read ports and one write port, all in the current mode. A debug port reads or writes any register as one named mode sees it. A mode-change strobe loads a new mode. Storage is physical and is never copied: a bank switch only changes which slots the architectural names point to. The block also drives a privilege flag and the current mode. The datapath has no flow-controlled interface. Every pin is a plain control or data signal sampled on the rising clock edge, so there is no back-pressure. Each write and each mode change lands at the edge where it is presented.

Top module: `mode_banked_regfile`

## Requirements
- R1: Mode to bank: modes 0/16 user, 1/17 fast-interrupt, 2/18 interrupt, 3/19 supervisor, 23 abort, 27 undefined. Every other value, including anything above 27, selects the scratch bank.
- R2: Both read ports are combinational. A write in the same cycle to the address being read is returned on that port at once (write-first).
- R3: A port write lands in the current bank at the rising edge. Registers 0 to 7 and 15 are common to all banks.
- R4: The fast-interrupt bank has private registers 8 to 14. After leaving it, the core sees the user values of 8 to 12 and the new bank's 13 and 14 again.
- R5: Two banks other than fast-interrupt and scratch share registers 8 to 12 and differ only in 13 and 14.
- R6: A mode change whose new mode maps to the current bank leaves every register as it was.
- R7: In the scratch bank, registers 8 to 14 read as zero on entry. Values written there are lost on leaving. A debug write aimed at the scratch bank from any other bank is dropped.
- R8: A debug access naming another mode reaches that mode's copy. One naming the current bank reaches the live registers. Debug reads are combinational.
- R9: A port write presented in the same cycle as a mode change lands in the bank of the old mode.
- R10: Mode output and privilege flag follow the mode one cycle after the strobe. The flag is 1 when either of mode bits 1:0 is 1.
- R11: After reset the mode is 19 (supervisor) and every register reads zero.
- R12: When the port write and a debug write target the same physical slot in one cycle, the port write wins. Writes to different slots both land.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_set | input | 1 | Load mode_in at the next edge |
| mode_in | input | 5 | New mode value |
| rd0_addr | input | 4 | Read port 0 register number |
| rd0_data | output | 32 | Read port 0 data |
| rd1_addr | input | 4 | Read port 1 register number |
| rd1_data | output | 32 | Read port 1 data |
| wr_en | input | 1 | Port write enable |
| wr_addr | input | 4 | Port write register number |
| wr_data | input | 32 | Port write data |
| dbg_mode | input | 5 | Mode whose view the debug port uses |
| dbg_addr | input | 4 | Debug register number |
| dbg_we | input | 1 | Debug write enable |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Debug read data |
| mode_o | output | 5 | Current mode |
| priv_o | output | 1 | Privilege flag |

## Verification
Read data and debug read data are valid in the same cycle as their address, with no clock edge in between. Writes, debug writes and mode changes show up in the cycle after the edge that takes them. The bench drives every stimulus on the falling edge. For a write or mode change it waits one full cycle before the dependent probe. Each probe pushes its expected values and then samples 1 ns after the falling edge, well away from the rising edge. For the write-first case it samples in the same half-cycle as the write.

// File: rtl/rb_pkg.sv
package rb_pkg;
  localparam int ARCH_REGS = 16;
  localparam int REG_AW    = $clog2(ARCH_REGS);
  localparam int HI_FIRST  = 8;
  localparam int HI_LAST   = 12;
  localparam int SP_IDX    = 13;
  localparam int LR_IDX    = 14;
  localparam int PC_IDX    = 15;
  localparam int MODE_TOP  = 27;

  localparam int HI_CNT    = HI_LAST - HI_FIRST + 1;
  localparam int NUM_BANKS = 7;
  localparam int HI_BASE   = HI_FIRST + 1;
  localparam int SL_BASE   = HI_BASE + 3 * HI_CNT;
  localparam int NUM_PHYS  = SL_BASE + 2 * NUM_BANKS;
  localparam int PIDX_W    = $clog2(NUM_PHYS);

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5,
    BK_DUM = 3'd6
  } bank_e;

  function automatic logic is_dummy_slot(input int i);
    return ((i >= HI_BASE + 2 * HI_CNT) && (i < HI_BASE + 3 * HI_CNT)) ||
           ((i >= SL_BASE + 2 * int'(BK_DUM)) && (i < SL_BASE + 2 * int'(BK_DUM) + 2));
  endfunction
endpackage

// File: rtl/rb_mode_decode.sv
module rb_mode_decode
  import rb_pkg::*;
#(
  parameter int MODE_W = 5
) (
  input  logic [MODE_W-1:0] mode,
  output bank_e             bank
);
  always_comb begin
    bank = BK_DUM;
    if (mode <= MODE_W'(MODE_TOP)) begin
      case (mode[3:0])
        4'd0:    bank = BK_USR;
        4'd1:    bank = BK_FIQ;
        4'd2:    bank = BK_IRQ;
        4'd3:    bank = BK_SVC;
        4'd7:    if (mode[4]) bank = BK_ABT;
        4'd11:   if (mode[4]) bank = BK_UND;
        default: bank = BK_DUM;
      endcase
    end
  end
endmodule

// File: rtl/rb_phys_map.sv
module rb_phys_map
  import rb_pkg::*;
(
  input  bank_e             bank,
  input  logic [REG_AW-1:0] areg,
  output logic [PIDX_W-1:0] idx
);
  logic [1:0] grp;

  always_comb begin
    case (bank)
      BK_FIQ:  grp = 2'd1;
      BK_DUM:  grp = 2'd2;
      default: grp = 2'd0;
    endcase
  end

  always_comb begin
    if (areg < REG_AW'(HI_FIRST))
      idx = PIDX_W'(int'(areg));
    else if (areg == REG_AW'(PC_IDX))
      idx = PIDX_W'(HI_BASE - 1);
    else if (areg <= REG_AW'(HI_LAST))
      idx = PIDX_W'(HI_BASE + HI_CNT * int'(grp) + int'(areg) - HI_FIRST);
    else
      idx = PIDX_W'(SL_BASE + 2 * int'(bank) + int'(areg) - SP_IDX);
  end
endmodule

// File: rtl/rb_storage.sv
module rb_storage
  import rb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NRD    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wipe,
  input  logic              cur_dum,
  input  logic              we_a,
  input  logic [PIDX_W-1:0] idx_a,
  input  logic [DATA_W-1:0] d_a,
  input  logic              we_b,
  input  logic [PIDX_W-1:0] idx_b,
  input  logic [DATA_W-1:0] d_b,
  input  logic [PIDX_W-1:0] ridx  [NRD],
  output logic [DATA_W-1:0] rdata [NRD]
);
  logic [DATA_W-1:0] mem [NUM_PHYS];
  logic              dum_live;

  // port A (core write) has priority over port B (debug write)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PHYS; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_PHYS; i++) begin
        if (wipe && is_dummy_slot(i))
          mem[i] <= '0;
        else if (we_a && idx_a == PIDX_W'(i))
          mem[i] <= d_a;
        else if (we_b && idx_b == PIDX_W'(i))
          mem[i] <= d_b;
      end
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata[r] = (int'(ridx[r]) < NUM_PHYS) ? mem[ridx[r]] : '0;
  end

  always_comb begin
    dum_live = 1'b0;
    for (int i = 0; i < NUM_PHYS; i++)
      if (is_dummy_slot(i)) dum_live = dum_live | (|mem[i]);
  end

  // R7: outside the scratch bank its slots hold nothing
  assert_dummy_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_dum |-> !dum_live);
endmodule

// File: rtl/mode_banked_regfile.sv
module mode_banked_regfile
  import rb_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter int                MODE_W     = 5,
  parameter logic [MODE_W-1:0] RESET_MODE = MODE_W'(19)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_set,
  input  logic [MODE_W-1:0] mode_in,
  input  logic [REG_AW-1:0] rd0_addr,
  output logic [DATA_W-1:0] rd0_data,
  input  logic [REG_AW-1:0] rd1_addr,
  output logic [DATA_W-1:0] rd1_data,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [MODE_W-1:0] dbg_mode,
  input  logic [REG_AW-1:0] dbg_addr,
  input  logic              dbg_we,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic [DATA_W-1:0] dbg_rdata,
  output logic [MODE_W-1:0] mode_o,
  output logic              priv_o
);
  localparam int NMAP = 4;
  localparam int NRD  = 3;
  localparam int NRP  = 2;

  logic [MODE_W-1:0] mode_q;
  bank_e             cur_bank, new_bank, dbg_bank;
  logic              bank_chg, wipe, dbg_hits_dummy, dbg_commit;

  bank_e             map_bank [NMAP];
  logic [REG_AW-1:0] map_reg  [NMAP];
  logic [PIDX_W-1:0] map_idx  [NMAP];
  logic [PIDX_W-1:0] st_ridx  [NRD];
  logic [DATA_W-1:0] st_rdata [NRD];
  logic [REG_AW-1:0] rp_addr  [NRP];
  logic [DATA_W-1:0] rp_data  [NRP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode_q <= RESET_MODE;
    else if (mode_set) mode_q <= mode_in;
  end

  rb_mode_decode #(.MODE_W(MODE_W)) u_dec_cur (.mode(mode_q),   .bank(cur_bank));
  rb_mode_decode #(.MODE_W(MODE_W)) u_dec_new (.mode(mode_in),  .bank(new_bank));
  rb_mode_decode #(.MODE_W(MODE_W)) u_dec_dbg (.mode(dbg_mode), .bank(dbg_bank));

  assign bank_chg = mode_set && (new_bank != cur_bank);
  assign wipe     = bank_chg && (cur_bank == BK_DUM || new_bank == BK_DUM);

  assign dbg_hits_dummy = (dbg_bank == BK_DUM) &&
                          (dbg_addr >= REG_AW'(HI_FIRST)) &&
                          (dbg_addr <= REG_AW'(LR_IDX));
  assign dbg_commit = dbg_we && !(dbg_hits_dummy && cur_bank != BK_DUM);

  assign map_bank[0] = cur_bank;  assign map_reg[0] = rd0_addr;
  assign map_bank[1] = cur_bank;  assign map_reg[1] = rd1_addr;
  assign map_bank[2] = cur_bank;  assign map_reg[2] = wr_addr;
  assign map_bank[3] = dbg_bank;  assign map_reg[3] = dbg_addr;

  for (genvar m = 0; m < NMAP; m++) begin : g_map
    rb_phys_map u_map (.bank(map_bank[m]), .areg(map_reg[m]), .idx(map_idx[m]));
  end

  assign st_ridx[0] = map_idx[0];
  assign st_ridx[1] = map_idx[1];
  assign st_ridx[2] = map_idx[3];

  rb_storage #(.DATA_W(DATA_W), .NRD(NRD)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wipe    (wipe),
    .cur_dum (cur_bank == BK_DUM),
    .we_a    (wr_en),
    .idx_a   (map_idx[2]),
    .d_a     (wr_data),
    .we_b    (dbg_commit),
    .idx_b   (map_idx[3]),
    .d_b     (dbg_wdata),
    .ridx    (st_ridx),
    .rdata   (st_rdata)
  );

  assign rp_addr[0] = rd0_addr;
  assign rp_addr[1] = rd1_addr;

  for (genvar p = 0; p < NRP; p++) begin : g_rport
    assign rp_data[p] = (wr_en && wr_addr == rp_addr[p]) ? wr_data : st_rdata[p];
  end

  assign rd0_data  = rp_data[0];
  assign rd1_data  = rp_data[1];
  assign dbg_rdata = st_rdata[2];
  assign mode_o    = mode_q;
  assign priv_o    = |mode_q[1:0];

  // R10: mode output follows the strobe one cycle later
  assert_mode_track_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_set |=> mode_o == $past(mode_in));

  // R10: privilege flag follows the low mode bits of the loaded mode
  assert_priv_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_set |=> priv_o == (|$past(mode_in[1:0])));

  // R2/R3: a value written without a mode change is read back next cycle
  assert_write_persists_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mode_set && rd0_addr == wr_addr) |=>
      (wr_en || rd0_addr != $past(rd0_addr) || rd0_data == $past(wr_data)));

  // R7: a debug write aimed at the scratch bank from outside has no effect
  assert_dbg_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_we && dbg_hits_dummy && cur_bank != BK_DUM && !mode_set && dbg_mode == $past(dbg_mode)) |=>
      (dbg_rdata == '0 || $past(dbg_addr) != dbg_addr || $past(dbg_mode) != dbg_mode));
endmodule

// File: tb/test_mode_banked_regfile.sv
`timescale 1ns/100ps
module test_mode_banked_regfile;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_set;
  logic [4:0]  mode_in;
  logic [3:0]  rd0_addr, rd1_addr, wr_addr, dbg_addr;
  logic [31:0] rd0_data, rd1_data, wr_data, dbg_wdata, dbg_rdata;
  logic        wr_en, dbg_we;
  logic [4:0]  dbg_mode, mode_o;
  logic        priv_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  typedef struct {
    int          kind;   // 0 rd0, 1 rd1, 2 dbg, 3 mode, 4 priv
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb_q[$];
  event sample_ev;

  always #2.5 clk = ~clk;

  mode_banked_regfile i_mode_banked_regfile (
    .clk(clk), .rst_n(rst_n), .mode_set(mode_set), .mode_in(mode_in),
    .rd0_addr(rd0_addr), .rd0_data(rd0_data), .rd1_addr(rd1_addr), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dbg_mode(dbg_mode), .dbg_addr(dbg_addr), .dbg_we(dbg_we), .dbg_wdata(dbg_wdata),
    .dbg_rdata(dbg_rdata), .mode_o(mode_o), .priv_o(priv_o)
  );

  // monitor: pops expectations and compares with the live outputs
  always begin
    @(sample_ev);
    while (sb_q.size() > 0) begin
      exp_t e;
      logic [31:0] got;
      e = sb_q.pop_front();
      case (e.kind)
        0:       got = rd0_data;
        1:       got = rd1_data;
        2:       got = dbg_rdata;
        3:       got = {27'd0, mode_o};
        default: got = {31'd0, priv_o};
      endcase
      checks++;
      if (got !== e.exp) begin
        errors++;
        $display("FAIL %s: got %h expected %h", e.tag, got, e.exp);
      end
    end
  end

  task automatic push_exp(input int k, input logic [31:0] v, input string t);
    exp_t e;
    e.kind = k; e.exp = v; e.tag = t;
    sb_q.push_back(e);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic setm(input logic [4:0] m);
    @(negedge clk); mode_set = 1'b1; mode_in = m;
    @(negedge clk); mode_set = 1'b0;
  endtask

  task automatic dwr(input logic [4:0] m, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); dbg_we = 1'b1; dbg_mode = m; dbg_addr = a; dbg_wdata = d;
    @(negedge clk); dbg_we = 1'b0;
  endtask

  task automatic expect_rd(input logic [3:0] a, input logic [31:0] v, input string t);
    @(negedge clk); rd0_addr = a; push_exp(0, v, t);
    #1 -> sample_ev;
  endtask

  task automatic expect_dbg(input logic [4:0] m, input logic [3:0] a, input logic [31:0] v, input string t);
    @(negedge clk); dbg_mode = m; dbg_addr = a; push_exp(2, v, t);
    #1 -> sample_ev;
  endtask

  task automatic expect_mode(input logic [4:0] m, input logic p, input string t);
    @(negedge clk); push_exp(3, {27'd0, m}, t); push_exp(4, {31'd0, p}, t);
    #1 -> sample_ev;
  endtask

  task automatic wr_bypass(input logic [3:0] a, input logic [31:0] d, input string t);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; rd0_addr = a; rd1_addr = a;
    push_exp(0, d, t); push_exp(1, d, t);
    #1 -> sample_ev;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic switch_with_write(input logic [4:0] m, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    mode_set = 1'b1; mode_in = m; wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); mode_set = 1'b0; wr_en = 1'b0;
  endtask

  task automatic dual_write(input logic [3:0] pa, input logic [31:0] pd,
                            input logic [4:0] dm, input logic [3:0] da, input logic [31:0] dd);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = pa; wr_data = pd;
    dbg_we = 1'b1; dbg_mode = dm; dbg_addr = da; dbg_wdata = dd;
    @(negedge clk); wr_en = 1'b0; dbg_we = 1'b0;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements): got hung run expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode_set = 1'b0; mode_in = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd0_addr = '0; rd1_addr = '0; dbg_mode = '0; dbg_addr = '0; dbg_we = 1'b0; dbg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state, supervisor mode 19, registers zero
    expect_mode(5'd19, 1'b1, "R11 reset mode");
    expect_rd(4'd3, 32'h0, "R11 reset r3");
    expect_dbg(5'd16, 4'd13, 32'h0, "R11 reset user r13");

    // R3: writes in supervisor
    wr(4'd13, 32'hA1A1_0013);
    wr(4'd8,  32'h0000_00B8);
    wr(4'd0,  32'h0000_00C0);
    expect_rd(4'd13, 32'hA1A1_0013, "R3 svc r13");

    // R2: write-first bypass on both ports
    wr_bypass(4'd5, 32'h0000_0055, "R2 bypass");
    expect_rd(4'd5, 32'h0000_0055, "R2 stored");

    // R5/R10: into user mode
    setm(5'd16);
    expect_mode(5'd16, 1'b0, "R10 user");
    expect_rd(4'd13, 32'h0, "R5 user r13 separate");
    expect_rd(4'd8, 32'h0000_00B8, "R5 r8 shared");
    expect_rd(4'd0, 32'h0000_00C0, "R3 r0 common");
    wr(4'd13, 32'hD000_0013);
    wr(4'd14, 32'hD000_0014);
    wr(4'd8,  32'hE000_0008);
    wr(4'd12, 32'hE000_0012);

    // R4: fast-interrupt private r8..r14
    setm(5'd17);
    expect_mode(5'd17, 1'b1, "R10 fiq");
    expect_rd(4'd8, 32'h0, "R4 fiq r8");
    expect_rd(4'd12, 32'h0, "R4 fiq r12");
    expect_rd(4'd13, 32'h0, "R4 fiq r13");
    expect_rd(4'd0, 32'h0000_00C0, "R3 fiq r0 common");
    wr(4'd8,  32'hF000_0008);
    wr(4'd13, 32'hF000_0013);

    // R8: debug views
    expect_dbg(5'd16, 4'd8, 32'hE000_0008, "R8 user shadow r8");
    expect_dbg(5'd17, 4'd8, 32'hF000_0008, "R8 live fiq r8");
    expect_dbg(5'd19, 4'd13, 32'hA1A1_0013, "R8 svc shadow r13");

    // R4: leave via mode 0
    setm(5'd0);
    expect_rd(4'd8, 32'hE000_0008, "R4 restore r8");
    expect_rd(4'd12, 32'hE000_0012, "R4 restore r12");
    expect_rd(4'd13, 32'hD000_0013, "R4 restore r13");
    expect_dbg(5'd1, 4'd8, 32'hF000_0008, "R1 mode1 is fiq");
    expect_dbg(5'd1, 4'd13, 32'hF000_0013, "R4 fiq r13 kept");

    // R6: same-bank mode change
    setm(5'd16);
    expect_rd(4'd13, 32'hD000_0013, "R6 r13");
    expect_rd(4'd14, 32'hD000_0014, "R6 r14");

    // R1: abort vs undefined vs unmapped
    dwr(5'd23, 4'd14, 32'h0000_00AB);
    expect_dbg(5'd23, 4'd14, 32'h0000_00AB, "R1 abort r14");
    expect_dbg(5'd27, 4'd14, 32'h0, "R1 undef separate");
    expect_dbg(5'd20, 4'd14, 32'h0, "R1 mode20 scratch");

    // R9: write with switch lands in old bank
    switch_with_write(5'd18, 4'd13, 32'h0000_9999);
    expect_mode(5'd18, 1'b1, "R9 irq mode");
    expect_rd(4'd13, 32'h0, "R9 irq r13");
    expect_dbg(5'd16, 4'd13, 32'h0000_9999, "R9 old bank got write");

    // R7: scratch bank
    dwr(5'd7, 4'd9, 32'h0000_0777);
    expect_dbg(5'd7, 4'd9, 32'h0, "R7 debug write dropped");
    setm(5'd7);
    expect_mode(5'd7, 1'b1, "R10 mode7");
    expect_rd(4'd9, 32'h0, "R7 entry r9");
    expect_rd(4'd13, 32'h0, "R7 entry r13");
    wr(4'd9, 32'h0000_0123);
    expect_rd(4'd9, 32'h0000_0123, "R7 live in scratch");
    setm(5'd16);
    expect_rd(4'd8, 32'hE000_0008, "R7 user r8 intact");
    expect_rd(4'd13, 32'h0000_9999, "R7 user r13 intact");
    expect_dbg(5'd31, 4'd9, 32'h0, "R7 discarded R1 mode31");
    setm(5'd28);
    expect_mode(5'd28, 1'b0, "R10 mode28");
    expect_rd(4'd9, 32'h0, "R7 reentry r9");
    setm(5'd16);

    // R12: simultaneous port and debug writes
    dual_write(4'd2, 32'h0000_0111, 5'd16, 4'd2, 32'h0000_0222);
    expect_rd(4'd2, 32'h0000_0111, "R12 port wins");
    dual_write(4'd3, 32'h0000_0333, 5'd16, 4'd4, 32'h0000_0444);
    expect_rd(4'd3, 32'h0000_0333, "R12 port lands");
    expect_rd(4'd4, 32'h0000_0444, "R12 debug lands");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule